// File: doc/BRIEF.md
# I2C GPIO Expander

This block is an I2C target that gives a controller sixteen general-purpose pins, grouped as two 8-bit ports. Eight byte-wide registers hold the port state. A pair of input registers returns the pin levels, a pair of output registers holds the values the pins drive, a pair of inversion masks acts on the returned levels, and a pair of direction masks selects input or output for each pin. The controller addresses the target with a fixed 4-bit prefix followed by three strap bits. The first byte it writes after the address is a command byte that sets the register pointer. The bytes that follow are written at the pointer. To read, the controller issues a repeated START and re-addresses with the read bit set. Data is then returned from the same pointer.

SCL and SDA are oversampled on the system clock through two-flop synchronizers. START and STOP are recognised as SDA edges that occur while SCL is high. The target pulls SDA low only while SCL is low, both to acknowledge and to drive read data. The block has no valid/ready stream edge. The I2C controller paces every byte, and the target never stretches SCL, so there is no back-pressure path. The pin outputs are plain registered levels.

Top module: `i2c_gpio_expander`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits are 0100 followed by strap[2:0], with the read/write flag in bit 0. After any other address it keeps SDA released, including during later ACK slots, until the next START, and it writes nothing.
- R2: In a write transfer, the first byte after the address is a command byte. Its low three bits set the register pointer. Every following data byte is acknowledged and written to the register at the pointer.
- R3: The pointer is kept across a repeated START and across STOP. A read addressed with the read flag set (bit 0 = 1) returns the register last selected by a command byte, whether or not a command byte came just before.
- R4: Register indices 0 and 1 return the synchronized levels of pin_i[7:0] and pin_i[15:8], whatever the pin direction. Writes to these indices change no register and no output.
- R5: The direction registers are index 6 (port 0) and index 7 (port 1). The output registers are index 2 (port 0) and index 3 (port 1). A direction bit of 1 sets pin_oe to 0 for that pin. A direction bit of 0 sets pin_oe to 1, and pin_o then carries the matching output-register bit. The pin outputs change only after a register write.
- R6: After reset, the output and direction registers read 8'hFF, the inversion registers read 8'h00, every pin_oe bit is 0 and SDA is released.
- R7: After each data byte, whether written or read, the pointer flips its bit 0 and keeps its bits 2:1. Consecutive bytes therefore alternate between the port-0 and port-1 register of one pair.
- R8: The inversion registers are index 4 (port 0) and index 5 (port 1). An inversion bit of 1 inverts the matching pin level returned from index 0 or 1.
- R9: If the controller answers a read byte with NACK (SDA high in the ACK slot), the target releases SDA and sends no further data until the next START.
- R10: The target samples SDA on rising SCL and changes its own SDA drive only while SCL is low. An SDA edge while SCL is low is data, not a START or a STOP, and a STOP followed by a START begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the I2C lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Low three bits of the target address |
| pin_i | input | 16 | Pin levels; bits 7:0 are port 0, bits 15:8 are port 1 |
| pin_oe | output | 16 | Per-pin output enable, 1 drives the pin |
| pin_o | output | 16 | Per-pin output value |

## Verification
Register reads and writes are run with one, two and three data bytes. The one-byte case checks pointer selection on its own. The two-byte case shows that both registers of a pair are reached. The three-byte case shows that the pointer wraps within the pair rather than moving to the next pair.

Pin patterns with different values in each port are read with the inversion masks off and then partly on. This separates the pin levels from the inversion and shows that the ports are not swapped. The same reads are repeated after writes aimed at the input indices, to show those writes had no effect.

Address bytes that differ from the strap value, and a changed strap value, test address matching. A NACK on a read, followed by further clocks, shows that the transfer ends. A read with no command byte after a STOP shows that the pointer is kept.

// File: rtl/gxp_pkg.sv
package gxp_pkg;
  localparam int BYTE_W  = 8;
  localparam int NPORTS  = 2;
  localparam int PINS_W  = BYTE_W * NPORTS;
  localparam int IDX_W   = 3;

  typedef enum logic [1:0] {
    K_IN  = 2'd0,
    K_OUT = 2'd1,
    K_POL = 2'd2,
    K_CFG = 2'd3
  } reg_kind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } link_state_t;
endpackage

// File: rtl/gxp_sync.sv
module gxp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gxp_regfile.sv
module gxp_regfile
  import gxp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OUT_RST = 8'hFF,
  parameter logic [BYTE_W-1:0] POL_RST = 8'h00,
  parameter logic [BYTE_W-1:0] CFG_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  input  logic [PINS_W-1:0] pin_s,
  output logic [BYTE_W-1:0] rd_data,
  output logic [PINS_W-1:0] pin_oe,
  output logic [PINS_W-1:0] pin_o
);
  logic [BYTE_W-1:0] out_r   [NPORTS];
  logic [BYTE_W-1:0] pol_r   [NPORTS];
  logic [BYTE_W-1:0] cfg_r   [NPORTS];
  logic [BYTE_W-1:0] pin_byte[NPORTS];

  reg_kind_t wr_kind, rd_kind;
  assign wr_kind = reg_kind_t'(wr_addr[2:1]);
  assign rd_kind = reg_kind_t'(rd_addr[2:1]);

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic hit;
      assign hit = wr_en && (wr_addr[0] == 1'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_r[p] <= OUT_RST;
          pol_r[p] <= POL_RST;
          cfg_r[p] <= CFG_RST;
        end else if (hit) begin
          case (wr_kind)
            K_OUT:   out_r[p] <= wr_data;
            K_POL:   pol_r[p] <= wr_data;
            K_CFG:   cfg_r[p] <= wr_data;
            default: ;
          endcase
        end
      end

      assign pin_byte[p]                = pin_s[p*BYTE_W +: BYTE_W];
      assign pin_oe[p*BYTE_W +: BYTE_W] = ~cfg_r[p];
      assign pin_o[p*BYTE_W +: BYTE_W]  = out_r[p];
    end
  endgenerate

  always_comb begin
    case (rd_kind)
      K_IN:    rd_data = pin_byte[rd_addr[0]] ^ pol_r[rd_addr[0]];
      K_OUT:   rd_data = out_r[rd_addr[0]];
      K_POL:   rd_data = pol_r[rd_addr[0]];
      default: rd_data = cfg_r[rd_addr[0]];
    endcase
  end
endmodule

// File: rtl/gxp_link.sv
module gxp_link
  import gxp_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              skip
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  link_state_t       state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txbyte;
  logic              rnw;
  logic              scl_q, sda_q;
  logic              start_det, stop_det, rise, fall;
  logic              byte_done;

  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise      = scl_s & ~scl_q;
  assign fall      = ~scl_s & scl_q;
  assign byte_done = fall && (bitcnt == FULL);

  assign wr_en   = (state == ST_WDAT) && byte_done;
  assign wr_data = shreg;
  assign skip    = (state == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txbyte <= '0;
      rnw    <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (rise && bitcnt != FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
              case (state)
                ST_ADDR: begin
                  if (shreg[BYTE_W-1:1] == {ADDR_HI, strap}) begin
                    rnw    <= shreg[0];
                    sda_oe <= 1'b1;
                    state  <= ST_AACK;
                  end else begin
                    state  <= ST_SKIP;
                  end
                end
                ST_CMD: begin
                  ptr    <= shreg[IDX_W-1:0];
                  sda_oe <= 1'b1;
                  state  <= ST_CACK;
                end
                default: begin
                  ptr[0] <= ~ptr[0];
                  sda_oe <= 1'b1;
                  state  <= ST_WACK;
                end
              endcase
            end
          end
          ST_AACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (rnw) begin
                txbyte <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                ptr[0] <= ~ptr[0];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_CMD;
              end
            end
          end
          ST_CACK, ST_WACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (rise) bitcnt <= bitcnt + 4'd1;
            if (fall) begin
              if (bitcnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                txbyte <= {txbyte[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txbyte[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (rise && sda_s) begin
              state <= ST_SKIP;
            end else if (fall) begin
              txbyte <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr[0] <= ~ptr[0];
              bitcnt <= '0;
              state  <= ST_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
  import gxp_pkg::*;
#(
  parameter logic [3:0]        ADDR_HI     = 4'b0100,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] OUT_RST     = 8'hFF,
  parameter logic [BYTE_W-1:0] POL_RST     = 8'h00,
  parameter logic [BYTE_W-1:0] CFG_RST     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic [PINS_W-1:0] pin_i,
  output logic [PINS_W-1:0] pin_oe,
  output logic [PINS_W-1:0] pin_o
);
  logic              scl_s, sda_s;
  logic [PINS_W-1:0] pin_s;
  logic              wr_en, skip;
  logic [IDX_W-1:0]  ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  gxp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  gxp_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  gxp_link #(.ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .strap(strap),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .ptr(ptr),
    .wr_data(wr_data), .skip(skip)
  );

  gxp_regfile #(.OUT_RST(OUT_RST), .POL_RST(POL_RST), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
    .rd_addr(ptr), .pin_s(pin_s), .rd_data(rd_data), .pin_oe(pin_oe), .pin_o(pin_o)
  );
endmodule

// File: rtl/gxp_checker.sv
module gxp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        skip,
  input logic        wr_en,
  input logic [2:0]  ptr,
  input logic [15:0] pin_oe,
  input logic [15:0] pin_o
);
  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !sda_oe);

  p_input_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr[2:1] == 2'b00) |=> ($stable(pin_oe) && $stable(pin_o)));

  p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_oe) && $stable(pin_o)));

  p_ptr_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == ($past(ptr) ^ 3'b001)));

  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));
endmodule

bind i2c_gpio_expander gxp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .skip(skip),
  .wr_en(wr_en), .ptr(ptr), .pin_oe(pin_oe), .pin_o(pin_o)
);

// File: tb/i2c_gpio_expander_tb.sv
module i2c_gpio_expander_tb;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_oe, bus_sda;
  logic [2:0]  strap = 3'b000;
  logic [15:0] pin_i = 16'h0000;
  logic [15:0] pin_oe, pin_o;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  assign bus_sda = m_sda & ~sda_oe;

  i2c_gpio_expander u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
    .strap(strap), .pin_i(pin_i), .pin_oe(pin_oe), .pin_o(pin_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(Q);
    s = bus_sda;  tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic rd);
    return {4'b0100, strap, rd};
  endfunction

  task automatic wr(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                    input logic [7:0] d1, input logic [7:0] d2, input string tag);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    wbyte(addr_byte(1'b0), ack); chk({tag, " addr ack"}, ack, 1);
    wbyte(cmd, ack);             chk({tag, " cmd ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(d[i], ack);          chk({tag, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic rd(input logic use_cmd, input logic [7:0] cmd, input int n,
                    input logic [7:0] e0, input logic [7:0] e1, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    if (use_cmd) begin
      wbyte(addr_byte(1'b0), ack); chk({tag, " addr ack"}, ack, 1);
      wbyte(cmd, ack);             chk({tag, " cmd ack"}, ack, 1);
      bus_start();
    end
    wbyte(addr_byte(1'b1), ack);   chk({tag, " raddr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back((i % 2 == 0) ? e0 : e1);
      tag_q.push_back(tag);
      rbyte(i < n - 1, b);
      got_q.push_back(b);
    end
    bus_stop();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " read data"}, g, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    tick(5);
    @(negedge clk);
    chk("R6 reset pin_oe", pin_oe, 16'h0000);
    chk("R6 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);

    rd(1, 8'd2, 2, 8'hFF, 8'hFF, "R6 out");
    rd(1, 8'd4, 2, 8'h00, 8'h00, "R6 pol");
    rd(1, 8'd6, 2, 8'hFF, 8'hFF, "R6 cfg");

    pin_i = 16'hA55A;
    rd(1, 8'd0, 2, 8'h5A, 8'hA5, "R4 inputs");

    wr(8'd6, 2, 8'h0F, 8'hF0, 8'h00, "R2 cfg");
    @(negedge clk); chk("R5 pin_oe", pin_oe, 16'h0FF0);
    wr(8'd2, 2, 8'h3C, 8'hC3, 8'h00, "R2 out");
    @(negedge clk); chk("R5 pin_o", pin_o, 16'hC33C);

    pin_i = 16'h1234;
    rd(1, 8'd0, 2, 8'h34, 8'h12, "R4 mixed dir");
    wr(8'd0, 2, 8'h00, 8'h00, 8'h00, "R4 input write");
    rd(1, 8'd0, 2, 8'h34, 8'h12, "R4 after write");
    @(negedge clk);
    chk("R4 pin_o held", pin_o, 16'hC33C);
    chk("R4 pin_oe held", pin_oe, 16'h0FF0);

    wr(8'd4, 2, 8'hFF, 8'h0F, 8'h00, "R8 pol");
    rd(1, 8'd0, 2, 8'hCB, 8'h1D, "R8 inverted");
    wr(8'd4, 2, 8'h00, 8'h00, 8'h00, "R8 pol clear");

    rd(1, 8'd2, 3, 8'h3C, 8'hC3, "R7 read wrap");
    wr(8'd3, 3, 8'h11, 8'h22, 8'h33, "R7 write wrap");
    rd(1, 8'd2, 2, 8'h22, 8'h33, "R7 after wrap");
    @(negedge clk); chk("R5 pin_o wrap", pin_o, 16'h3322);

    bus_start();
    wbyte({4'b0100, 3'b010, 1'b0}, ack); chk("R1 wrong addr nack", ack, 0);
    wbyte(8'h02, ack);                   chk("R1 silent after mismatch", ack, 0);
    wbyte(8'h00, ack);                   chk("R1 silent data", ack, 0);
    bus_stop();
    rd(1, 8'd2, 2, 8'h22, 8'h33, "R1 no write");

    strap = 3'b101;
    bus_start();
    wbyte(8'h40, ack); chk("R1 old strap nack", ack, 0);
    bus_stop();
    wr(8'd6, 2, 8'hAA, 8'h55, 8'h00, "R1 strap 101");
    @(negedge clk); chk("R1 pin_oe via new addr", pin_oe, 16'hAA55);
    rd(1, 8'd6, 2, 8'hAA, 8'h55, "R1 read back");
    strap = 3'b000;

    bus_start();
    wbyte(addr_byte(1'b0), ack); chk("R9 addr ack", ack, 1);
    wbyte(8'd2, ack);            chk("R9 cmd ack", ack, 1);
    bus_start();
    wbyte(addr_byte(1'b1), ack); chk("R9 raddr ack", ack, 1);
    rbyte(1'b0, b);              chk("R9 first byte", b, 8'h22);
    rbyte(1'b1, b);              chk("R9 released after nack", b, 8'hFF);
    bus_stop();

    wr(8'd7, 0, 8'h00, 8'h00, 8'h00, "R3 ptr set");
    rd(0, 8'd0, 1, 8'h55, 8'h00, "R3 ptr kept");

    wr(8'd2, 2, 8'hA5, 8'h5A, 8'h00, "R10 edges");
    @(negedge clk); chk("R10 pin_o after data edges", pin_o, 16'h5AA5);
    rd(1, 8'd3, 1, 8'h5A, 8'h00, "R2 single");

    tick(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule